// File: doc/BRIEF.md
# Powerdown and Self-Calibration Sequencer

This block sequences a clock-recovery receiver from a single active-high control input that serves both as powerdown and as calibration trigger. While the input is high, the block turns the serial output drivers off and holds the recovery loop in reset. When the input returns low after a long enough high time, the block starts a self-calibration of the loop. It waits first if the reference clock is not yet valid. When the calibration stub reports completion, the block issues a one-cycle acquisition start and then settles in normal operation.

A high pulse that is too short does not trigger calibration. The loop simply leaves reset and begins acquisition with its existing trim. The block also gates the loss-of-lock indicator, so no alarm can be raised while the receiver is powered down, waiting for a reference or calibrating. A timeout flag reports when the path from release to acquisition takes longer than the allowed window.

Top module: `pdcal_ctrl`

## Requirements
- R1: One cycle after the control input is sampled high, `drv_en` is 0 and `loop_rst` is 1, and both stay so while the input stays high.
- R2: A falling edge that follows at least `CYC_PER_US*MIN_HIGH_US` consecutive high samples, with `ref_ok` high, raises `cal_active` in the next cycle and releases `loop_rst`.
- R3: A falling edge that follows fewer high samples than that minimum starts no calibration. In the next cycle `acq_start` pulses for one cycle and `drv_en` returns to 1.
- R4: If `ref_ok` is low at a qualified falling edge, the block waits with `cal_active` low, `loop_rst` high and `drv_en` high. Calibration begins one cycle after `ref_ok` is sampled high.
- R5: When `cal_done` is sampled high during calibration with `ref_ok` high, `acq_start` is high for exactly the next cycle. After that the block is in normal operation with `lol_gate` high.
- R6: If `ref_ok` is sampled low during calibration, calibration is abandoned. The block returns to waiting (`cal_active` low, `loop_rst` high) and recalibrates once the reference returns.
- R7: `lol_gate` is 0 whenever the block is powered down, waiting for the reference or calibrating.
- R8: `cal_late` rises after `CYC_PER_US*TIMEOUT_US` cycles spent waiting for the reference or calibrating. It stays high until the next powerdown, which clears it.
- R9: A high control input overrides every state, including an ongoing calibration: `cal_active` drops and the drivers are disabled one cycle later.
- R10: After reset the block is in normal operation: `drv_en`=1, `lol_gate`=1, `loop_rst`=0, `cal_active`=0, `acq_start`=0 and `cal_late`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_cal | input | 1 | Powerdown when high; a qualified falling edge requests calibration (already synchronized) |
| ref_ok | input | 1 | Reference clock is present and valid |
| cal_done | input | 1 | Calibration engine reports completion |
| drv_en | output | 1 | Enable for the recovered data and clock drivers |
| loop_rst | output | 1 | Holds the recovery loop logic in reset |
| cal_active | output | 1 | Calibration is in progress |
| lol_gate | output | 1 | Allows the lock detector to assert loss of lock |
| acq_start | output | 1 | One-cycle pulse that starts lock acquisition |
| cal_late | output | 1 | Release-to-acquisition time exceeded the timeout |

## Verification
The hardest condition to reach is the timeout. It needs the block to linger in the waiting or calibrating phase for a full window, and then it must be shown that only the next powerdown clears the flag. The bench shrinks the timing parameters, withholds `ref_ok` after a qualified release, and checks the flag one cycle before and exactly at the limit. It then completes the calibration and confirms the flag persists until a new high pulse. The high-time qualifier is checked at both sides of the threshold, one sample short and exactly at the limit.

// File: rtl/pdcal_ctrl.sv
module pdcal_ctrl #(
  parameter int CYC_PER_US  = 250,
  parameter int MIN_HIGH_US = 1,
  parameter int TIMEOUT_US  = 1700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_cal,
  input  logic ref_ok,
  input  logic cal_done,
  output logic drv_en,
  output logic loop_rst,
  output logic cal_active,
  output logic lol_gate,
  output logic acq_start,
  output logic cal_late
);

  localparam int MIN_HI = CYC_PER_US * MIN_HIGH_US;
  localparam int TMO    = CYC_PER_US * TIMEOUT_US;
  localparam int HW     = $clog2(MIN_HI + 1);
  localparam int TW     = $clog2(TMO + 1);

  typedef enum logic [2:0] {
    S_PDOWN   = 3'd0,
    S_WAITREF = 3'd1,
    S_CAL     = 3'd2,
    S_ACQ     = 3'd3,
    S_RUN     = 3'd4
  } st_t;

  st_t st_q, st_d;
  logic [HW-1:0] hi_q;
  logic [TW-1:0] tmo_q;
  logic qualified;

  assign qualified = (hi_q >= HW'(MIN_HI));

  always_comb begin
    st_d = st_q;
    if (pd_cal) begin
      st_d = S_PDOWN;
    end else begin
      unique case (st_q)
        S_PDOWN:   st_d = !qualified ? S_ACQ : (ref_ok ? S_CAL : S_WAITREF);
        S_WAITREF: if (ref_ok) st_d = S_CAL;
        S_CAL:     if (!ref_ok) st_d = S_WAITREF;
                   else if (cal_done) st_d = S_ACQ;
        S_ACQ:     st_d = S_RUN;
        S_RUN:     st_d = S_RUN;
        default:   st_d = S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_RUN;
      hi_q  <= '0;
      tmo_q <= '0;
    end else begin
      st_q <= st_d;
      if (pd_cal) begin
        if (st_q != S_PDOWN) hi_q <= HW'(1);
        else if (!qualified) hi_q <= hi_q + HW'(1);
      end else if (st_q != S_PDOWN) begin
        hi_q <= '0;
      end
      if (st_q == S_PDOWN)
        tmo_q <= '0;
      else if ((st_q == S_WAITREF || st_q == S_CAL) && tmo_q != TW'(TMO))
        tmo_q <= tmo_q + TW'(1);
    end
  end

  assign drv_en     = (st_q != S_PDOWN);
  assign loop_rst   = (st_q == S_PDOWN) || (st_q == S_WAITREF);
  assign cal_active = (st_q == S_CAL);
  assign lol_gate   = (st_q == S_ACQ) || (st_q == S_RUN);
  assign acq_start  = (st_q == S_ACQ);
  assign cal_late   = (tmo_q == TW'(TMO));

endmodule

module pdcal_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_cal,
  input logic ref_ok,
  input logic cal_done,
  input logic drv_en,
  input logic loop_rst,
  input logic cal_active,
  input logic lol_gate,
  input logic acq_start,
  input logic cal_late
);

  AST_DRV_OFF_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    pd_cal |=> (!drv_en && loop_rst)); // R1

  AST_CAL_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_active) |-> $past(ref_ok)); // R2

  AST_REF_LOSS_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && !ref_ok && !pd_cal) |=> (!cal_active && loop_rst)); // R6

  AST_DONE_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && cal_done && ref_ok && !pd_cal) |=> acq_start); // R5

  AST_ACQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !acq_start); // R5

  AST_LOL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active || !drv_en || loop_rst) |-> !lol_gate); // R7

  AST_PD_ABORTS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && pd_cal) |=> !cal_active); // R9

  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_late && drv_en) |=> (cal_late || !drv_en)); // R8

endmodule

bind pdcal_ctrl pdcal_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_cal(pd_cal), .ref_ok(ref_ok), .cal_done(cal_done),
  .drv_en(drv_en), .loop_rst(loop_rst), .cal_active(cal_active), .lol_gate(lol_gate),
  .acq_start(acq_start), .cal_late(cal_late)
);

// File: tb/pdcal_ctrl_tb_top.sv
module pdcal_ctrl_tb_top;
  localparam int CPU = 4;
  localparam int MHU = 2;
  localparam int TOU = 10;
  localparam int MIN_HI = CPU * MHU;
  localparam int TMO = CPU * TOU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_cal = 1'b0, ref_ok = 1'b1, cal_done = 1'b0;
  logic drv_en, loop_rst, cal_active, lol_gate, acq_start, cal_late;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdcal_ctrl #(.CYC_PER_US(CPU), .MIN_HIGH_US(MHU), .TIMEOUT_US(TOU)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_cal(pd_cal), .ref_ok(ref_ok), .cal_done(cal_done),
    .drv_en(drv_en), .loop_rst(loop_rst), .cal_active(cal_active),
    .lol_gate(lol_gate), .acq_start(acq_start), .cal_late(cal_late));

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Hold the input high for n sampling edges, release, and wait for the decision edge.
  task automatic pulse_high(int n);
    @(negedge clk) pd_cal = 1'b1;
    repeat (n) @(negedge clk);
    pd_cal = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_cal();
    cal_done = 1'b1;
    @(negedge clk) cal_done = 1'b0;
    chk("R5", "acq_start", acq_start, 1'b1);
    @(negedge clk);
    chk("R5", "acq_start drop", acq_start, 1'b0);
    chk("R5", "lol_gate", lol_gate, 1'b1);
  endtask

  task automatic t_reset();
    chk("R10", "drv_en", drv_en, 1'b1);
    chk("R10", "lol_gate", lol_gate, 1'b1);
    chk("R10", "loop_rst", loop_rst, 1'b0);
    chk("R10", "cal_active", cal_active, 1'b0);
    chk("R10", "acq_start", acq_start, 1'b0);
    chk("R10", "cal_late", cal_late, 1'b0);
  endtask

  task automatic t_short_pulse();
    @(negedge clk) pd_cal = 1'b1;
    @(negedge clk);
    chk("R1", "drv_en", drv_en, 1'b0);
    chk("R1", "loop_rst", loop_rst, 1'b1);
    chk("R7", "lol_gate in pd", lol_gate, 1'b0);
    repeat (MIN_HI - 2) @(negedge clk);
    chk("R1", "drv_en held", drv_en, 1'b0);
    pd_cal = 1'b0;
    @(negedge clk);
    chk("R3", "no cal", cal_active, 1'b0);
    chk("R3", "acq_start", acq_start, 1'b1);
    chk("R3", "drv_en", drv_en, 1'b1);
    @(negedge clk);
    chk("R3", "acq_start drop", acq_start, 1'b0);
  endtask

  task automatic t_normal_cal();
    ref_ok = 1'b1;
    pulse_high(MIN_HI);
    chk("R2", "cal_active", cal_active, 1'b1);
    chk("R2", "loop_rst", loop_rst, 1'b0);
    chk("R7", "lol_gate in cal", lol_gate, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2", "cal held", cal_active, 1'b1);
    finish_cal();
    chk("R8", "no late", cal_late, 1'b0);
  endtask

  task automatic t_wait_ref();
    ref_ok = 1'b0;
    pulse_high(MIN_HI);
    chk("R4", "cal_active", cal_active, 1'b0);
    chk("R4", "loop_rst", loop_rst, 1'b1);
    chk("R4", "drv_en", drv_en, 1'b1);
    chk("R7", "lol_gate waiting", lol_gate, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4", "still waiting", cal_active, 1'b0);
    ref_ok = 1'b1;
    @(negedge clk);
    chk("R4", "cal after ref", cal_active, 1'b1);
    ref_ok = 1'b0;
    @(negedge clk);
    chk("R6", "cal abandoned", cal_active, 1'b0);
    chk("R6", "loop_rst", loop_rst, 1'b1);
    ref_ok = 1'b1;
    @(negedge clk);
    chk("R6", "recal", cal_active, 1'b1);
    finish_cal();
  endtask

  task automatic t_timeout();
    ref_ok = 1'b0;
    pulse_high(MIN_HI);
    repeat (TMO - 1) @(negedge clk);
    chk("R8", "below limit", cal_late, 1'b0);
    @(negedge clk);
    chk("R8", "at limit", cal_late, 1'b1);
    ref_ok = 1'b1;
    @(negedge clk);
    finish_cal();
    repeat (2) @(negedge clk);
    chk("R8", "sticky in run", cal_late, 1'b1);
    @(negedge clk) pd_cal = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8", "cleared by pd", cal_late, 1'b0);
    pd_cal = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pd_abort();
    ref_ok = 1'b1;
    pulse_high(MIN_HI);
    chk("R2", "cal started", cal_active, 1'b1);
    pd_cal = 1'b1;
    @(negedge clk);
    chk("R9", "cal_active", cal_active, 1'b0);
    chk("R9", "drv_en", drv_en, 1'b0);
    pd_cal = 1'b0;
    @(negedge clk);
    chk("R3", "short abort acq", acq_start, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_pulse();
    t_normal_cal();
    t_wait_ref();
    t_timeout();
    t_pd_abort();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule